// File: doc/BRIEF.md
# Timer Capture Unit with Two-Entry FIFO

This block timestamps transitions on one asynchronous input pin. It brings the pin into the clock domain with a two-flop synchronizer. It then accepts a new level only after that level has stayed steady for a qualification window. When the accepted level changes in the direction that software selected, the block records the count of one of two free-running 16-bit timers. The recorded value goes into a small first-in first-out store.

Software reaches the block through a simple register port. It selects the edge type, the timebase and the interrupt enable, and it reads the store occupancy and the event flag. Each read of the data register takes out the oldest capture. Each recorded event raises a sticky flag, and the flag drives the interrupt output when the enable bit allows it. One instance serves one capture channel.

The register port has no back-pressure. It is always ready: a write takes effect at the clock edge on which `reg_wr` is high, and read data is combinational from `reg_addr`. The capture stream never stalls either. A capture into a full store discards the oldest entry, so producer and consumer need no handshake.

Top module: `cap_unit`

## Requirements
- R1: After reset the occupancy is 00, the flag is 0, `irq` is 0, the control register reads 0 and the data register reads 0.
- R2: A pin level is accepted only after the synchronized level has held across two consecutive rising clock edges. A pin pulse that lasts one clock period is ignored. A change driven between clock edges is captured on the fourth rising edge that follows it.
- R3: Status bits [1:0] (address 1) encode occupancy: 00 means empty, 01 means one entry, 10 means two entries. The value 11 never appears.
- R4: Control bits [1:0] (address 0) select the capture edge: 00 means none, 01 means rising, 10 means falling, 11 means both.
- R5: Control bit 2 selects the timebase: 0 captures `tmr_a`, 1 captures `tmr_b`.
- R6: A read of the data register (address 2) with `reg_rd` high returns the oldest entry and removes it. Entries come out in capture order.
- R7: A capture into a full store discards the oldest entry, keeps the newest two and leaves the occupancy at 10.
- R8: A read of the data register while the store is empty returns the most recently removed value (0 after reset) and leaves the occupancy unchanged.
- R9: Status bit 2 is the event flag. Every capture sets it. Writing 1 to that bit clears it, and writing 0 has no effect. A capture in the same cycle as a clear leaves the flag set.
- R10: `irq` equals the flag ANDed with control bit 3.
- R11: Control bits [3:0] read back as written. Address 3 reads 0, and the data register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_a | input | 16 | Count of timebase A |
| tmr_b | input | 16 | Count of timebase B |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe; removes an entry when it targets the data register |
| reg_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The bound checker checks a set of properties on every cycle. The occupancy code stays legal. The flag follows every capture, and the occupancy steps correctly on a push into an empty store, on a push into a full store, and on removals. The interrupt stays low while it is masked. Some behaviour can only be shown by the bench's scenarios, because it depends on what the pin and the timers did: the exact four-edge capture latency, the filtering of a one-period glitch, the per-mode edge choice, the timebase choice, the order of captured values with the oldest-dropping overflow, and the value returned by a read of the empty store.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_W      = 4;
  localparam int CTRL_TSEL_B = 2;
  localparam int CTRL_IEN_B  = 3;
  localparam int STAT_FLAG_B = 2;
endpackage

// File: rtl/cap_sync_qual.sv
module cap_sync_qual #(
  parameter int QUAL_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [1:0]          meta;
  logic [QUAL_LEN-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) meta <= '0;
    else        meta <= {meta[0], pin};
  end

  generate
    if (QUAL_LEN == 1) begin : g_q1
      assign win = meta[1];
    end else if (QUAL_LEN == 2) begin : g_q2
      logic hist;
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= meta[1];
      end
      assign win = {hist, meta[1]};
    end else begin : g_qn
      logic [QUAL_LEN-2:0] hist;
      always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[QUAL_LEN-3:0], meta[1]};
      end
      assign win = {hist, meta[1]};
    end
  endgenerate

  assign rise = (&win) & ~lvl;
  assign fall = ~(|win) & lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)    lvl <= 1'b0;
    else if (rise) lvl <= 1'b1;
    else if (fall) lvl <= 1'b0;
  end
endmodule

// File: rtl/cap_edge_sel.sv
module cap_edge_sel
  import cap_pkg::*;
(
  input  edge_mode_e mode,
  input  logic       rise,
  input  logic       fall,
  output logic       evt
);
  always_comb begin
    unique case (mode)
      EDGE_RISE: evt = rise;
      EDGE_FALL: evt = fall;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem   [DEPTH];
  logic [W-1:0]  nxt   [DEPTH];
  logic [W-1:0]  last;
  logic [CW-1:0] cnt, ncnt;
  logic          do_pop;

  assign do_pop = pop && (cnt != '0);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = mem[i];
    ncnt = cnt;
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) nxt[i] = nxt[i+1];
      ncnt = cnt - 1'b1;
    end
    if (push) begin
      if (ncnt == CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH - 1; i++) nxt[i] = nxt[i+1];
        nxt[DEPTH-1] = din;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (ncnt == CW'(i)) nxt[i] = din;
        ncnt = ncnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt  <= '0;
      last <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
      cnt <= ncnt;
      if (do_pop) last <= mem[0];
    end
  end

  assign dout = (cnt != '0) ? mem[0] : last;
  assign occ  = cnt;
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int TW       = 16,
  parameter int DEPTH    = 2,
  parameter int QUAL_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pin,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [TW-1:0] reg_wdata,
  input  logic          reg_rd,
  output logic [TW-1:0] reg_rdata,
  output logic          irq
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q;
  logic              lvl, rise, fall, cap_evt, pop;
  logic [TW-1:0]     cap_val, head;
  logic [OCC_W-1:0]  occ;
  edge_mode_e        mode;

  assign mode    = edge_mode_e'(ctrl_q[1:0]);
  assign cap_val = ctrl_q[CTRL_TSEL_B] ? tmr_b : tmr_a;
  assign pop     = reg_rd && (reg_addr == ADDR_DATA);

  cap_sync_qual #(.QUAL_LEN(QUAL_LEN)) u_sq (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  cap_edge_sel u_es (
    .mode(mode), .rise(rise), .fall(fall), .evt(cap_evt)
  );

  cap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cap_evt), .din(cap_val),
    .pop(pop), .dout(head), .occ(occ)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (cap_evt)
        flag_q <= 1'b1;
      else if (reg_wr && reg_addr == ADDR_STAT && reg_wdata[STAT_FLAG_B])
        flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_STAT: begin
        reg_rdata[OCC_W-1:0]   = occ;
        reg_rdata[STAT_FLAG_B] = flag_q;
      end
      ADDR_DATA: reg_rdata = head;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = flag_q & ctrl_q[CTRL_IEN_B];
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cap_evt,
  input logic       pop,
  input logic [1:0] occ,
  input logic       flag,
  input logic       irq_en,
  input logic       irq
);
  p_occ_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ != 2'b11);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag);

  p_push_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && occ == 2'b00) |=> occ == 2'b01);

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !cap_evt && occ == 2'b10) |=> occ == 2'b01);

  p_full_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && occ == 2'b10) |=> occ == 2'b10);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !cap_evt && occ == 2'b00) |=> occ == 2'b00);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind cap_unit cap_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .pop(pop),
  .occ(occ), .flag(flag_q), .irq_en(ctrl_q[3]), .irq(irq)
);

// File: tb/sim_cap_unit.sv
`timescale 1ns/1ps
module sim_cap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [15:0] tmr_a = '0, tmr_b = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic [15:0] obs;
  string       mon_tag;
  event        mon_ev;
  logic [15:0] rv;

  always #4 clk = ~clk;

  cap_unit u0 (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each observed data read against the scoreboard
  always @(mon_ev) begin
    if (exp_q.size() == 0) chk({mon_tag, " (nothing expected)"}, obs, 16'hxxxx);
    else chk(mon_tag, obs, exp_q.pop_front());
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b0; #1 d = reg_rdata;
  endtask

  task automatic pop_chk(input string tag);
    @(negedge clk); reg_addr = 2'd2; reg_rd = 1'b1; #1 obs = reg_rdata;
    mon_tag = tag; ->mon_ev;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); cap_pin = v;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rdreg(2'd1, rv); chk("R1 status", rv, 16'h0000);
    rdreg(2'd0, rv); chk("R1 ctrl", rv, 16'h0000);
    rdreg(2'd2, rv); chk("R1 data", rv, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    wr(2'd0, 16'h0001);                       // R4 rising, R5 timer A
    tmr_a = 16'h1111; exp_q.push_back(16'h1111);
    set_pin(1); settle();
    rdreg(2'd1, rv); chk("R3/R9 one entry and flag", rv, 16'h0005);
    set_pin(0); settle();
    rdreg(2'd1, rv); chk("R4 falling ignored in rising mode", rv[1:0], 16'h0001);
    @(negedge clk) cap_pin = 1'b1; @(negedge clk) cap_pin = 1'b0; settle();
    rdreg(2'd1, rv); chk("R2 one-period glitch ignored", rv[1:0], 16'h0001);

    tmr_a = 16'h2222; exp_q.push_back(16'h2222);
    set_pin(1); repeat (3) @(posedge clk);
    rdreg(2'd1, rv); chk("R2 not yet captured after 3 edges", rv[1:0], 16'h0001);
    rdreg(2'd1, rv); chk("R2 captured on 4th edge", rv[1:0], 16'h0002);
    set_pin(0); settle();

    tmr_a = 16'h3333; exp_q.push_back(16'h3333); void'(exp_q.pop_front());
    set_pin(1); settle();
    rdreg(2'd1, rv); chk("R7 full stays 10", rv[1:0], 16'h0002);
    set_pin(0); settle();
    pop_chk("R7 oldest dropped, R6 order first");
    pop_chk("R6 order second");
    rdreg(2'd1, rv); chk("R3 empty", rv[1:0], 16'h0000);
    exp_q.push_back(16'h3333);
    pop_chk("R8 empty read returns last");
    rdreg(2'd1, rv); chk("R8 occupancy unchanged", rv[1:0], 16'h0000);

    chk("R10 masked irq", {15'd0, irq}, 16'h0000);
    wr(2'd0, 16'h0009);
    #1 chk("R10 enabled irq", {15'd0, irq}, 16'h0001);
    wr(2'd1, 16'h0000);
    rdreg(2'd1, rv); chk("R9 write 0 keeps flag", {15'd0, rv[2]}, 16'h0001);
    wr(2'd1, 16'h0004);
    rdreg(2'd1, rv); chk("R9 write 1 clears flag", {15'd0, rv[2]}, 16'h0000);
    chk("R10 irq follows flag", {15'd0, irq}, 16'h0000);

    tmr_a = 16'h4444; exp_q.push_back(16'h4444);
    set_pin(1); repeat (3) @(posedge clk);
    @(negedge clk); reg_addr = 2'd1; reg_wdata = 16'h0004; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rdreg(2'd1, rv); chk("R9 capture beats same-cycle clear", {15'd0, rv[2]}, 16'h0001);
    set_pin(0); settle();
    pop_chk("R6 single entry");

    wr(2'd0, 16'h0006);                       // falling, timer B
    tmr_a = 16'hAAAA; tmr_b = 16'hBEEF;
    set_pin(1); settle();
    rdreg(2'd1, rv); chk("R4 rising ignored in falling mode", rv[1:0], 16'h0000);
    exp_q.push_back(16'hBEEF);
    set_pin(0); settle();
    pop_chk("R5 timer B selected on falling edge");

    wr(2'd0, 16'h0007);                       // both edges, timer B
    tmr_b = 16'h0101; exp_q.push_back(16'h0101); set_pin(1); settle();
    tmr_b = 16'h0202; exp_q.push_back(16'h0202); set_pin(0); settle();
    rdreg(2'd1, rv); chk("R4 both edges captured", rv[1:0], 16'h0002);
    pop_chk("R4 both first");
    pop_chk("R4 both second");

    wr(2'd0, 16'h0004);                       // no edge
    set_pin(1); settle(); set_pin(0); settle();
    rdreg(2'd1, rv); chk("R4 mode none captures nothing", rv[1:0], 16'h0000);
    rdreg(2'd0, rv); chk("R11 ctrl readback", rv, 16'h0004);
    rdreg(2'd3, rv); chk("R11 unused address", rv, 16'h0000);
    wr(2'd2, 16'hFFFF);
    rdreg(2'd2, rv); chk("R11 data ignores write", rv, 16'h0202);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule